// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block is a synchronous master that turns single-beat read and write requests from a host into correctly timed strobe sequences on a byte-wide asynchronous static memory. The memory has a 19-bit address, an 8-bit data bus, and active-low chip enable, output enable and write enable. The host presents requests through a valid/ready handshake. Read data comes back on a response channel that holds its value until the host takes it.

Every memory timing figure is given as a nanosecond parameter. Each figure is turned into a whole number of clock cycles by rounding up. Several constraints that govern the same phase are folded into a single phase length, so that no single rule can be short. A per-request style input picks one of two write styles. In the write-enable-terminated style, write enable rises first and chip enable follows. In the chip-enable-terminated style, chip enable rises first and the longer chip-enable hold rules apply.

The data bus is split into an output, an output-enable and an input, so that the pad ring can join them. The controller never drives the bus while output enable is low. It also never drives the bus while the memory might still be releasing it after a read.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high, the data bus is not driven, reqReady is high and rspValid is low.
- R2: With the default parameters (5 ns clock), a read holds chip enable and output enable low, with write enable high, for exactly 14 cycles. The data seen on memDqIn in the last of those cycles is returned on rspRdata. rspValid first appears 14 rising edges after the edge that accepted the request.
- R3: rspValid stays high, with rspRdata unchanged, until a cycle in which rspReady is high. reqReady stays low while a response is pending. With rspReady held high, rspValid is a single-cycle pulse.
- R4: When wrStyleCe is 0 at acceptance, a write proceeds as follows. There is one cycle with the address and data driven and both enables high. Then chip enable and write enable go low together for 12 cycles. Write enable rises first, and chip enable rises one cycle later.
- R5: When wrStyleCe is 1 at acceptance, the write has the same setup cycle and the same 12-cycle joint low window. Chip enable then rises first, and write enable stays low for 3 more cycles.
- R6: The data bus is driven only during a write, from its setup cycle through its hold cycles: 14 cycles in the style of R4 and 16 in the style of R5. It is never driven while output enable is low, nor in the cycle right after output enable was low.
- R7: Output enable is high in every cycle in which write enable is low.
- R8: The memory address is stable while either enable is low. Address changes are at least 70 ns apart. After a write, the address is held 5 ns past write enable rising, or 15 ns past chip enable rising. Write data is set up at least 30 ns before the write ends and is held 10 ns past a chip-enable-terminated end.
- R9: After a read ends, the controller waits 5 cycles before it accepts its next request. This keeps the bus undriven for at least 25 ns after the memory outputs are turned off.
- R10: A read returns the byte most recently written to the same address, including at addresses 0 and 7FFFF hex.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Request byte address |
| reqWdata | input | 8 | Write data |
| wrStyleCe | input | 1 | Write style: 0 = write enable ends the write, 1 = chip enable ends it |
| rspValid | output | 1 | Read data available |
| rspReady | input | 1 | Host takes the read data |
| rspRdata | output | 8 | Read data |
| memAddr | output | 19 | Memory address |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memDqOut | output | 8 | Data toward the memory |
| memDqOe | output | 1 | Drive memDqOut onto the bus |
| memDqIn | input | 8 | Data from the memory bus |

## Verification
Suppose the phase counter or state register is wrong. The effect appears within one access at the strobe pins: an enable window that is one or more cycles too short or too long, or a response that arrives on the wrong edge. A timing-checking memory model catches these through cycle-time and hold checks at the next address change. Suppose instead the latched write style is corrupted. The order of the enable rising edges flips at the end of that same write, and the written byte or the hold check shows the error on the following read. A stuck bus-drive flag shows as contention on the next read, or as a late write-data edge, within that same access.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

  // Strobes the controller hands to the datapath; levels describe the next cycle.
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic ceN;
    logic oeN;
    logic weN;
    logic dqDrive;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_RREC,
    S_WADR,
    S_WPUL,
    S_WHLD
  } ctrlState_e;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int nsToCyc(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/100ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int LEN_RD      = 14,
  parameter int LEN_RREC    = 5,
  parameter int LEN_WADR    = 1,
  parameter int LEN_WPUL    = 12,
  parameter int LEN_HOLD_WE = 1,
  parameter int LEN_HOLD_CE = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         wrStyleCe,
  input  logic         rspPending,
  output logic         reqReady,
  output ctrlStrobes_t str
);

  localparam int MAX_A   = maxOf(maxOf(LEN_RD, LEN_RREC), maxOf(LEN_WADR, LEN_WPUL));
  localparam int MAX_LEN = maxOf(MAX_A, maxOf(LEN_HOLD_WE, LEN_HOLD_CE));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  ctrlState_e       state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             styleCe, styleNxt;

  function automatic logic [CNT_W-1:0] lenCode(input int len);
    return CNT_W'(len - 1);
  endfunction

  assign reqReady = (state == S_IDLE) && !rspPending;

  always_comb begin
    stateNxt    = state;
    cntNxt      = cnt;
    styleNxt    = styleCe;
    str         = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid && !rspPending) begin
          str.loadReq = 1'b1;
          if (reqWrite) begin
            stateNxt = S_WADR;
            cntNxt   = lenCode(LEN_WADR);
            styleNxt = wrStyleCe;
          end else begin
            stateNxt = S_RD;
            cntNxt   = lenCode(LEN_RD);
          end
        end
      end
      S_RD: begin
        if (cnt == '0) begin
          str.capture = 1'b1;
          stateNxt    = S_RREC;
          cntNxt      = lenCode(LEN_RREC);
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      S_RREC: begin
        if (cnt == '0) stateNxt = S_IDLE;
        else           cntNxt   = cnt - CNT_W'(1);
      end
      S_WADR: begin
        if (cnt == '0) begin
          stateNxt = S_WPUL;
          cntNxt   = lenCode(LEN_WPUL);
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      S_WPUL: begin
        if (cnt == '0) begin
          stateNxt = S_WHLD;
          cntNxt   = styleCe ? lenCode(LEN_HOLD_CE) : lenCode(LEN_HOLD_WE);
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      S_WHLD: begin
        if (cnt == '0) stateNxt = S_IDLE;
        else           cntNxt   = cnt - CNT_W'(1);
      end
      default: stateNxt = S_IDLE;
    endcase

    // Pin levels for the cycle that follows this edge.
    str.ceN     = !((stateNxt == S_RD) || (stateNxt == S_WPUL) ||
                    ((stateNxt == S_WHLD) && !styleNxt));
    str.oeN     = (stateNxt != S_RD);
    str.weN     = !((stateNxt == S_WPUL) || ((stateNxt == S_WHLD) && styleNxt));
    str.dqDrive = (stateNxt == S_WADR) || (stateNxt == S_WPUL) || (stateNxt == S_WHLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      styleCe <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      styleCe <= styleNxt;
    end
  end

  // R9: leaving a read always passes through the recovery phase first.
  p_read_recovers_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == S_RD && state != S_RD) |-> state == S_RREC);

endmodule

// File: rtl/sram_ctrl_dp.sv
`timescale 1ns/100ps
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int MIN_WR_PULSE = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      str,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic              rspReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int PC_W = $clog2(MIN_WR_PULSE + 1) + 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memDqOe  <= 1'b0;
    end else begin
      if (str.loadReq) begin
        memAddr <= reqAddr;
        if (reqWrite) memDqOut <= reqWdata;
      end
      memCeN  <= str.ceN;
      memOeN  <= str.oeN;
      memWeN  <= str.weN;
      memDqOe <= str.dqDrive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else if (str.capture) begin
      rspValid <= 1'b1;
      rspRdata <= memDqIn;
    end else if (rspReady) begin
      rspValid <= 1'b0;
    end
  end

  // Length of the current joint-low write window, saturating.
  logic [PC_W-1:0] wrLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      wrLowCnt <= '0;
    else if (!memCeN && !memWeN) begin
      if (wrLowCnt != '1)           wrLowCnt <= wrLowCnt + PC_W'(1);
    end else                        wrLowCnt <= '0;
  end

  // R4: a write window is never shorter than the minimum pulse width.
  p_wr_pulse_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!memCeN && !memWeN) && !(!memCeN && !memWeN)) |-> wrLowCnt >= PC_W'(MIN_WR_PULSE));

  // R6: bus driven only after output enable has been high for a full cycle.
  p_drive_oe_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && $past(memOeN)));

  // R7: no read-style output enable while writing.
  p_oe_high_wr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R8: address frozen while an enable stays low.
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!memCeN || !memWeN) && (!memCeN || !memWeN)) |-> $stable(memAddr));

  // R3: an unaccepted response keeps its value.
  p_rsp_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspRdata)));

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/100ps
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 5,
  parameter int T_ACC_NS    = 70,  // address / chip-enable access
  parameter int T_OE_ACC_NS = 35,  // output-enable access
  parameter int T_CYC_NS    = 70,  // minimum cycle time
  parameter int T_HZ_NS     = 25,  // memory output turn-off after read
  parameter int T_AS_NS     = 0,   // address setup before an enable falls
  parameter int T_WP_NS     = 55,  // write pulse width
  parameter int T_DS_NS     = 30,  // data setup before write end
  parameter int T_AW_NS     = 65,  // address valid to write end
  parameter int T_AH_WE_NS  = 5,
  parameter int T_AH_CE_NS  = 15,
  parameter int T_DH_WE_NS  = 0,
  parameter int T_DH_CE_NS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              wrStyleCe,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int C_ACC    = nsToCyc(T_ACC_NS, CLK_NS);
  localparam int C_OEACC  = nsToCyc(T_OE_ACC_NS, CLK_NS);
  localparam int C_CYC    = nsToCyc(T_CYC_NS, CLK_NS);
  localparam int C_HZ     = nsToCyc(T_HZ_NS, CLK_NS);
  localparam int C_AS     = nsToCyc(T_AS_NS, CLK_NS);
  localparam int C_WP     = nsToCyc(T_WP_NS, CLK_NS);
  localparam int C_DS     = nsToCyc(T_DS_NS, CLK_NS);
  localparam int C_AW     = nsToCyc(T_AW_NS, CLK_NS);
  localparam int C_AH_WE  = nsToCyc(T_AH_WE_NS, CLK_NS);
  localparam int C_AH_CE  = nsToCyc(T_AH_CE_NS, CLK_NS);
  localparam int C_DH_WE  = nsToCyc(T_DH_WE_NS, CLK_NS);
  localparam int C_DH_CE  = nsToCyc(T_DH_CE_NS, CLK_NS);

  localparam int LEN_RD      = maxOf(maxOf(C_ACC, C_OEACC), C_CYC);
  localparam int LEN_RREC    = maxOf(1, C_HZ);
  localparam int LEN_WADR    = maxOf(1, C_AS);
  localparam int LEN_WPUL    = maxOf(maxOf(C_WP, C_DS), C_AW - LEN_WADR);
  localparam int WR_REST     = C_CYC - LEN_WADR - LEN_WPUL;
  localparam int LEN_HOLD_WE = maxOf(maxOf(1, WR_REST), maxOf(C_AH_WE, C_DH_WE));
  localparam int LEN_HOLD_CE = maxOf(maxOf(1, WR_REST), maxOf(C_AH_CE, C_DH_CE));

  ctrlStrobes_t strobes;

  sram_ctrl_fsm #(
    .LEN_RD      (LEN_RD),
    .LEN_RREC    (LEN_RREC),
    .LEN_WADR    (LEN_WADR),
    .LEN_WPUL    (LEN_WPUL),
    .LEN_HOLD_WE (LEN_HOLD_WE),
    .LEN_HOLD_CE (LEN_HOLD_CE)
  ) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .wrStyleCe  (wrStyleCe),
    .rspPending (rspValid),
    .reqReady   (reqReady),
    .str        (strobes)
  );

  sram_ctrl_dp #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .MIN_WR_PULSE (C_WP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .str      (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqWrite (reqWrite),
    .rspReady (rspReady),
    .rspValid (rspValid),
    .rspRdata (rspRdata),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memDqIn  (memDqIn)
  );

endmodule

// File: tb/sram_cycle_ctrl_tb_top.sv
`timescale 1ns/100ps
module async_sram_model (
  input  logic        armed,
  input  logic [18:0] memAddr,
  input  logic        memCeN,
  input  logic        memOeN,
  input  logic        memWeN,
  input  logic [7:0]  memDqOut,
  input  logic        memDqOe,
  output logic [7:0]  memDqIn
);
  int      violCount = 0;
  logic    lastEndByCe = 1'b0;
  realtime tAddr = -1000.0, tWrStart = 0.0, tWrEnd = -1000.0;
  realtime tRdStart = 0.0, tRdEnd = -1000.0, tData = -1000.0;
  logic [18:0] tagMem [1024];
  logic [7:0]  datMem [1024];
  logic        vldMem [1024];

  wire rdAct = !memCeN && !memOeN && memWeN;
  wire wrAct = !memCeN && !memWeN;

  initial for (int i = 0; i < 1024; i++) vldMem[i] = 1'b0;

  function automatic void flag(input string msg);
    violCount++;
    $display("  model timing violation at %0t: %s", $realtime, msg);
  endfunction

  always_comb begin
    if (rdAct && vldMem[memAddr[9:0]] && tagMem[memAddr[9:0]] == memAddr)
      memDqIn = datMem[memAddr[9:0]];
    else if (rdAct) memDqIn = 8'h00;
    else            memDqIn = 8'hEE;
  end

  always @(memAddr) if (armed) begin
    if (wrAct) flag("address moved inside write");
    if ($realtime - tAddr < 70.0) flag("cycle time");
    if ($realtime - tWrEnd < (lastEndByCe ? 15.0 : 5.0)) flag("address hold");
    tAddr = $realtime;
  end

  always @(wrAct) if (armed) begin
    if (wrAct) tWrStart = $realtime;
    else begin
      if ($realtime - tWrStart < 55.0) flag("write pulse");
      if ($realtime - tData < 30.0) flag("data setup");
      if ($realtime - tAddr < 65.0) flag("address to write end");
      lastEndByCe = memCeN;
      tWrEnd = $realtime;
      tagMem[memAddr[9:0]] = memAddr;
      datMem[memAddr[9:0]] = memDqOe ? memDqOut : 8'hEE;
      vldMem[memAddr[9:0]] = 1'b1;
    end
  end

  always @(memDqOut or memDqOe) if (armed) begin
    if (!wrAct && ($realtime - tWrEnd < (lastEndByCe ? 10.0 : 0.0))) flag("data hold");
    tData = $realtime;
  end

  always @(rdAct) if (armed) begin
    if (rdAct) tRdStart = $realtime;
    else begin
      if ($realtime - tRdStart < 70.0) flag("read access");
      tRdEnd = $realtime;
    end
  end

  always @(posedge memDqOe) if (armed && ($realtime - tRdEnd < 25.0)) flag("drive before release");
  always @(memDqOe or rdAct) if (armed && memDqOe && rdAct) flag("bus contention");
endmodule

module sram_cycle_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b1, modelArm = 1'b0;
  logic        reqValid = 0, reqWrite = 0, wrStyleCe = 0, rspReady = 1;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid, memCeN, memOeN, memWeN, memDqOe;
  logic [7:0]  rspRdata, memDqOut, memDqIn;
  logic [18:0] memAddr;

  sram_cycle_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .wrStyleCe(wrStyleCe), .rspValid(rspValid), .rspReady(rspReady),
    .rspRdata(rspRdata), .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn));

  async_sram_model model_i (
    .armed(modelArm), .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn));

  int checks = 0, failures = 0;
  logic [18:0] pool [18];
  logic [7:0]  refData [18];

  // Expected figures taken from the requirements (5 ns clock).
  function automatic int expRdLen();            return 14; endfunction
  function automatic int expRecovery();         return 5;  endfunction
  function automatic int expCeLow(input bit s); return s ? 12 : 13; endfunction
  function automatic int expWeLow(input bit s); return s ? 15 : 12; endfunction
  function automatic int expDrive(input bit s); return s ? 16 : 14; endfunction

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  task automatic accept(input bit wr, input int pi, input logic [7:0] d, input bit st);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = pool[pi]; reqWdata = d; wrStyleCe = st;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doWrite(input int pi, input logic [7:0] d, input bit st);
    int prevV = model_i.violCount;
    int ceLo = 0, weLo = 0, oeLo = 0, drv = 0, n = 0;
    accept(1'b1, pi, d, st);
    while (!reqReady && n < 100) begin
      ceLo += int'(!memCeN); weLo += int'(!memWeN);
      oeLo += int'(!memOeN); drv += int'(memDqOe);
      @(negedge clk); n++;
    end
    refData[pi] = d;
    if (st) begin
      chk(ceLo == expCeLow(1), "R5", "chip enable low cycles", ceLo, expCeLow(1));
      chk(weLo == expWeLow(1), "R5", "write enable low cycles", weLo, expWeLow(1));
    end else begin
      chk(ceLo == expCeLow(0), "R4", "chip enable low cycles", ceLo, expCeLow(0));
      chk(weLo == expWeLow(0), "R4", "write enable low cycles", weLo, expWeLow(0));
    end
    chk(model_i.lastEndByCe == st, "R4_R5", "terminating enable", int'(model_i.lastEndByCe), int'(st));
    chk(oeLo == 0, "R7", "output enable low during write", oeLo, 0);
    chk(drv == expDrive(st), "R6", "bus drive cycles", drv, expDrive(st));
    chk(model_i.violCount == prevV, "R8", "write timing violations", model_i.violCount - prevV, 0);
  endtask

  task automatic doRead(input int pi, input bit holdRsp);
    int prevV = model_i.violCount;
    int both = 0, drv = 0, n = 0, m = 0;
    logic [7:0] got;
    rspReady = !holdRsp;
    accept(1'b0, pi, 8'h00, 1'b0);
    while (!rspValid && n < 100) begin
      both += int'(!memCeN && !memOeN && memWeN);
      drv  += int'(memDqOe);
      @(negedge clk); n++;
    end
    got = rspRdata;
    chk(n == expRdLen(), "R2", "response latency", n, expRdLen());
    chk(both == expRdLen(), "R2", "read strobe window", both, expRdLen());
    chk(drv == 0, "R6", "bus driven during read", drv, 0);
    chk(got == refData[pi], "R10", "read data", int'(got), int'(refData[pi]));
    if (holdRsp) begin
      repeat (6) @(negedge clk);
      chk(rspValid == 1'b1 && rspRdata == got, "R3", "held response", int'(rspRdata), int'(got));
      chk(reqReady == 1'b0, "R3", "ready while response pending", int'(reqReady), 0);
      rspReady = 1;
      @(negedge clk);
      chk(rspValid == 1'b0, "R3", "response cleared", int'(rspValid), 0);
    end else begin
      while (!reqReady && m < 100) begin
        @(negedge clk); m++;
        if (m == 1) chk(rspValid == 1'b0, "R3", "response pulse width", int'(rspValid), 0);
        if (memDqOe) chk(1'b0, "R9", "bus driven in recovery", 1, 0);
      end
      chk(m == expRecovery(), "R9", "recovery cycles", m, expRecovery());
    end
    chk(model_i.violCount == prevV, "R8", "read timing violations", model_i.violCount - prevV, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL all watchdog: actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      pool[i] = {9'($urandom_range(0, 511)), 10'(i * 61 + 7)};
    end
    pool[16] = 19'h00000;
    pool[17] = 19'h7FFFF;
    for (int i = 0; i < 18; i++) refData[i] = 8'h00;

    #1 rstN = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    chk(memCeN && memOeN && memWeN, "R1", "strobes after reset",
        int'({memCeN, memOeN, memWeN}), 7);
    chk(!memDqOe, "R1", "bus drive after reset", int'(memDqOe), 0);
    chk(reqReady && !rspValid, "R1", "handshake after reset",
        int'({reqReady, rspValid}), 2);
    modelArm = 1;

    // Directed corners.
    doRead(16, 1'b0);                // unwritten address reads zero
    doWrite(16, 8'hFF, 1'b0);
    doWrite(17, 8'h00, 1'b1);
    doRead(16, 1'b0);
    doRead(17, 1'b0);
    doWrite(17, 8'hA5, 1'b0);
    doRead(17, 1'b1);                // held response
    doWrite(3, 8'h3C, 1'b1);
    doWrite(3, 8'hC3, 1'b0);         // overwrite, other style
    doRead(3, 1'b0);
    doRead(3, 1'b0);                 // read after read

    // Random traffic.
    for (int k = 0; k < 60; k++) begin
      int pi = $urandom_range(0, 17);
      if ($urandom_range(0, 1) == 1)
        doWrite(pi, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      else
        doRead(pi, $urandom_range(0, 7) == 0);
    end

    repeat (5) @(negedge clk);
    chk(model_i.violCount == 0, "R8", "total timing violations", model_i.violCount, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule